// File: doc/BRIEF.md
# Multiword Scalar Multiply-Accumulate Chain

This block multiplies an unsigned integer of up to `MAX_LEN` 64-bit digits by one 64-bit scalar. It walks the digits from least to most significant. For each digit it forms the 128-bit value `digit * scalar + carry`, writes the low half back as the result digit, and keeps the high half as the carry for the next digit. The carry into digit 0 is zero. The carry left after the last digit is the extra top digit of the product. It appears on `carry_out` while `done` pulses.

The operand sits in an external digit store. The block reads that store through a simple read port: `rd_en` and `rd_idx` request a digit, and the store returns it on `rd_data` one cycle later. Result digits leave through a write port made of `wr_en`, `wr_idx` and `wr_data`. The multiplier is a pipelined 64x64 unit of `MUL_LAT` register stages.

A single controller sequences each digit through these states:
- `ST_IDLE`: waits for `start`.
- `ST_FETCH`: issues the read.
- `ST_LOAD`: the digit arrives and enters the multiplier.
- `ST_WAIT`: waits for the product.
- `ST_ACCUM`: adds the carry, writes the digit and updates the carry.
- `ST_FINISH`: pulses `done`.

The transitions are:
- idle→fetch: start with a non-zero length.
- idle→finish: start with a zero length.
- fetch→load: always.
- load→wait: always.
- wait→accum: the product is valid.
- accum→fetch: more digits remain.
- accum→finish: the last digit is done.
- finish→idle: always.

Top module: `mw_mac_chain`

## Requirements
- R1: Result digit i equals the low 64 bits of `A[i]*B + C[i-1]`, where `C[i-1]` is the high 64 bits of step i-1 and the carry into step 0 is zero.
- R2: While `done` is high, `carry_out` equals the high 64 bits of the last step. This holds for every operand value, including all-ones digits with an all-ones scalar, which need the full 128 bits.
- R3: A run with effective length L makes exactly L writes, with `wr_idx` taking the values 0, 1, …, L-1 in that order. `done` is raised only after the L-th write.
- R4: A run with effective length L issues exactly L reads, with `rd_idx` taking the values 0, 1, …, L-1 in ascending order. The digit is taken from `rd_data` in the cycle after `rd_en`.
- R5: `done` is high for exactly one cycle per accepted start. `busy` is low in the cycle after `done`.
- R6: A start with `vlen` = 0 makes no reads and no writes. It raises `done` in the cycle after the start, with `carry_out` = 0.
- R7: While `busy` is high, `start`, `vlen` and `scalar` have no effect, and the running product completes unchanged. `busy` stays high from the accepted start through the `done` cycle.
- R8: After reset, `busy`, `done`, `rd_en` and `wr_en` are low. Whenever `busy` is low, `rd_en`, `wr_en` and `done` stay low.
- R9: A `vlen` above `MAX_LEN` is treated as `MAX_LEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a product; accepted only while idle |
| vlen | input | LEN_W | Number of digits, sampled at start |
| scalar | input | 64 | Scalar multiplier, sampled at start |
| rd_en | output | 1 | Digit read request |
| rd_idx | output | IDX_W | Index of the digit requested |
| rd_data | input | 64 | Digit returned one cycle after rd_en |
| wr_en | output | 1 | Result digit write strobe |
| wr_idx | output | IDX_W | Index of the result digit |
| wr_data | output | 64 | Result digit value |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 64 | Final carry digit, valid with done |
| busy | output | 1 | A product is in progress |

## Verification
A carry that is lost or stale between steps corrupts result digit i+1. It shows up on the write port one digit period later, and then in `carry_out` at `done`. A step counter that runs ahead or lags shows up at once as a skipped or repeated `wr_idx`/`rd_idx`, and also as a write count that differs from the requested length when `done` arrives. A controller that lingers in or skips a state shows up as a `done` pulse that is wider than one cycle, a missing `done`, or a zero-length start that fails to finish on the next cycle. The random runs use all-ones digits to stress the full carry range, and they also restart the block while it is busy.

// File: rtl/mwm_pkg.sv
package mwm_pkg;
    localparam int DIGIT_W = 64;
    localparam int WIDE_W  = 2 * DIGIT_W;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [WIDE_W-1:0]  wide_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_WAIT,
        ST_ACCUM,
        ST_FINISH
    } state_t;
endpackage

// File: rtl/mwm_mul.sv
module mwm_mul
    import mwm_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    input  digit_t a,
    input  digit_t b,
    output logic   out_valid,
    output wide_t  product
);
    wide_t      raw;
    wide_t      stg [1:LAT];
    logic [LAT:1] vld;

    assign raw = WIDE_W'(a) * WIDE_W'(b);

    // Valid bits shift every cycle; data registers load only with a valid
    // token so the last stage holds its product until the next issue.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            for (int k = 1; k <= LAT; k++) begin
                if (k == 1) vld[k] <= in_valid;
                else        vld[k] <= vld[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 1; k <= LAT; k++) begin
            if (k == 1) begin
                if (in_valid) stg[k] <= raw;
            end else begin
                if (vld[k-1]) stg[k] <= stg[k-1];
            end
        end
    end

    assign out_valid = vld[LAT];
    assign product   = stg[LAT];
endmodule

// File: rtl/mwm_carry_acc.sv
module mwm_carry_acc
    import mwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   step,
    input  wide_t  product,
    output digit_t sum_lo,
    output digit_t carry_q
);
    wide_t sum;

    // Max of product plus carry is (2^64-1)^2 + (2^64-1) < 2^128: no wrap.
    assign sum    = product + {{DIGIT_W{1'b0}}, carry_q};
    assign sum_lo = sum[DIGIT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= '0;
        end else if (clear) begin
            carry_q <= '0;
        end else if (step) begin
            carry_q <= sum[WIDE_W-1:DIGIT_W];
        end
    end
endmodule

// File: rtl/mw_mac_chain.sv
module mw_mac_chain
    import mwm_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int MUL_LAT = 2,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int IDX_W  = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] vlen,
    input  logic [63:0]      scalar,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [63:0]      rd_data,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [63:0]      wr_data,
    output logic             done,
    output logic [63:0]      carry_out,
    output logic             busy
);
    state_t           state_q, state_d;
    logic [LEN_W-1:0] idx_q, idx_d;
    logic [LEN_W-1:0] len_q, len_d;
    digit_t           scalar_q, scalar_d;
    logic [LEN_W-1:0] eff_len;
    logic [LEN_W-1:0] idx_next;

    logic   mul_in_valid, mul_out_valid;
    wide_t  mul_product;
    logic   acc_clear, acc_step;
    digit_t acc_lo, acc_carry;

    assign eff_len  = (vlen > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : vlen;
    assign idx_next = idx_q + LEN_W'(1);

    mwm_mul #(.LAT(MUL_LAT)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (mul_in_valid),
        .a         (rd_data),
        .b         (scalar_q),
        .out_valid (mul_out_valid),
        .product   (mul_product)
    );

    mwm_carry_acc u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (acc_clear),
        .step    (acc_step),
        .product (mul_product),
        .sum_lo  (acc_lo),
        .carry_q (acc_carry)
    );

    // Next-state and datapath-register update.
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        len_d    = len_q;
        scalar_d = scalar_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    idx_d    = '0;
                    len_d    = eff_len;
                    scalar_d = scalar;
                    state_d  = (eff_len == '0) ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FETCH: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (mul_out_valid) state_d = ST_ACCUM;
            end
            ST_ACCUM: begin
                idx_d   = idx_next;
                state_d = (idx_next == len_q) ? ST_FINISH : ST_FETCH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            len_q    <= '0;
            scalar_q <= '0;
        end else begin
            state_q  <= state_d;
            idx_q    <= idx_d;
            len_q    <= len_d;
            scalar_q <= scalar_d;
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        rd_en        = 1'b0;
        wr_en        = 1'b0;
        done         = 1'b0;
        mul_in_valid = 1'b0;
        acc_clear    = 1'b0;
        acc_step     = 1'b0;
        unique case (state_q)
            ST_IDLE:   acc_clear    = start;
            ST_FETCH:  rd_en        = 1'b1;
            ST_LOAD:   mul_in_valid = 1'b1;
            ST_WAIT:   ;
            ST_ACCUM: begin
                wr_en    = 1'b1;
                acc_step = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
        busy      = (state_q != ST_IDLE);
        rd_idx    = idx_q[IDX_W-1:0];
        wr_idx    = idx_q[IDX_W-1:0];
        wr_data   = acc_lo;
        carry_out = acc_carry;
    end
endmodule

// File: rtl/mwm_chk.sv
module mwm_chk #(
    parameter int MAX_LEN = 16,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int IDX_W  = $clog2(MAX_LEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] vlen,
    input logic             rd_en,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             done,
    input logic [63:0]      carry_out,
    input logic             busy
);
    logic             accept;
    logic [LEN_W-1:0] cnt_q, len_q;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (accept) begin
            cnt_q <= '0;
            len_q <= (vlen > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : vlen;
        end else if (wr_en) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    p_wr_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx == cnt_q[IDX_W-1:0]);
    p_wr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cnt_q < len_q);
    p_done_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cnt_q == len_q);
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && vlen == '0) |=> done && carry_out == 64'd0);
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_en && !wr_en && !done);
endmodule

bind mw_mac_chain mwm_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vlen      (vlen),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .done      (done),
    .carry_out (carry_out),
    .busy      (busy)
);

// File: tb/tb_mw_mac_chain.sv
`timescale 1ns/1ps
module tb_mw_mac_chain;
    localparam int MAX_LEN = 16;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int IDX_W   = $clog2(MAX_LEN);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] vlen = '0;
    logic [63:0]      scalar = '0;
    logic             rd_en;
    logic [IDX_W-1:0] rd_idx;
    logic [63:0]      rd_data = '0;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [63:0]      wr_data;
    logic             done;
    logic [63:0]      carry_out;
    logic             busy;

    always #2 clk = ~clk;

    mw_mac_chain #(.MAX_LEN(MAX_LEN), .MUL_LAT(2)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .scalar(scalar),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .done(done), .carry_out(carry_out), .busy(busy)
    );

    logic [63:0] mem     [MAX_LEN];
    logic [63:0] res     [MAX_LEN];
    logic [63:0] exp_dig [MAX_LEN];
    logic [63:0] exp_carry;
    int errors = 0;
    int checks = 0;
    int wr_cnt, rd_cnt, wr_bad, rd_bad;

    // Digit store: data appears before the edge following rd_en.
    always @(negedge clk) begin
        if (rd_en) begin
            rd_data = mem[rd_idx];
            if (int'(rd_idx) != rd_cnt) rd_bad++;
            rd_cnt++;
        end
        if (wr_en) begin
            res[wr_idx] = wr_data;
            if (int'(wr_idx) != wr_cnt) wr_bad++;
            wr_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model(input int n, input logic [63:0] b);
        logic [127:0] w;
        logic [63:0]  c;
        c = '0;
        for (int i = 0; i < n; i++) begin
            w = 128'(mem[i]) * 128'(b) + 128'(c);
            exp_dig[i] = w[63:0];
            c = w[127:64];
        end
        exp_carry = c;
    endfunction

    task automatic run(input int vl, input logic [63:0] b, input bit poke,
                       input string tag);
        int eff;
        int cyc;
        eff = (vl > MAX_LEN) ? MAX_LEN : vl;
        model(eff, b);
        for (int i = 0; i < MAX_LEN; i++) res[i] = '0;
        wr_cnt = 0; rd_cnt = 0; wr_bad = 0; rd_bad = 0;
        @(negedge clk);
        start = 1'b1; vlen = LEN_W'(vl); scalar = b;
        @(negedge clk);
        start = 1'b0; vlen = LEN_W'($urandom_range(1, MAX_LEN));
        scalar = {$urandom, $urandom};
        cyc = 0;
        while (!done && cyc < 5000) begin
            start = (poke && (cyc == 3 || cyc == 9)) ? 1'b1 : 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(done, {tag, " R5 done seen"}, 128'(done), 128'(1));
        chk(wr_cnt == eff, {tag, " R3 write count"}, 128'(wr_cnt), 128'(eff));
        chk(wr_bad == 0, {tag, " R3 write order"}, 128'(wr_bad), 128'(0));
        chk(rd_cnt == eff && rd_bad == 0, {tag, " R4 read count/order"},
            128'(rd_cnt), 128'(eff));
        for (int i = 0; i < eff; i++)
            chk(res[i] == exp_dig[i], {tag, " R1 digit"}, 128'(res[i]),
                128'(exp_dig[i]));
        chk(carry_out == exp_carry, {tag, " R2 final carry"}, 128'(carry_out),
            128'(exp_carry));
        @(negedge clk);
        chk(!done && !busy, {tag, " R5 one-cycle done"}, 128'({done, busy}),
            128'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en, "R8 reset state",
            128'({busy, done, rd_en, wr_en}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en, "R8 idle after reset",
            128'({busy, done, rd_en, wr_en}), 128'(0));

        // Directed corner cases.
        for (int i = 0; i < MAX_LEN; i++) mem[i] = {$urandom, $urandom};
        run(1, 64'd3, 1'b0, "single");
        run(0, {$urandom, $urandom}, 1'b0, "R6 zero-length");
        for (int i = 0; i < MAX_LEN; i++) mem[i] = '1;
        run(MAX_LEN, '1, 1'b0, "R2 all-ones");
        for (int i = 0; i < MAX_LEN; i++) mem[i] = {$urandom, $urandom};
        run(MAX_LEN, 64'd0, 1'b0, "zero scalar");
        run(5, 64'd1, 1'b0, "unit scalar");
        run(MAX_LEN + 3, {$urandom, $urandom}, 1'b0, "R9 clamp");
        run(6, {$urandom, $urandom}, 1'b1, "R7 start while busy");

        // Random runs.
        for (int t = 0; t < 12; t++) begin
            for (int i = 0; i < MAX_LEN; i++)
                mem[i] = ($urandom_range(0, 3) == 0) ? '1 : {$urandom, $urandom};
            run($urandom_range(0, MAX_LEN), {$urandom, $urandom},
                1'($urandom_range(0, 1)), "random R1");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule